// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous DRAM and takes the memory from power-on to an operational state. From reset onward it holds clock-enable and the byte masks high and drives a no-operation command. It then waits for a stabilization time given in nanoseconds, which is converted to whole clock cycles from a clock-frequency parameter. After the wait it closes every bank with a single precharge-all command, issues a programmable number of auto refresh commands and writes the mode register. The burst length, burst ordering and CAS latency written to the mode register come from parameters.

Each command is followed by a parameterized number of NOP cycles. These cover the precharge recovery time, the refresh cycle time and, when the mode write comes first, the mode-set recovery time. A parameter selects whether the refreshes come before or after the mode register write. After the last step a done flag rises and stays high, with the command pins idle, until the next reset. Pulling the active-low reset restarts the whole sequence from the beginning of the wait.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low and at all times after, `sd_cke` is 1 and every `sd_dqm` bit is 1. Reset forces a NOP command, where NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1, and forces `init_done` low.
- R2: After the last clock edge that samples `rst_n` low, exactly WAIT_CYC = ceil(WAIT_NS * CLK_KHZ / 1,000,000) NOP cycles are driven. The precharge command follows them.
- R3: The precharge-all command is cs_n=0, ras_n=1... precisely cs_n=0, ras_n=0, cas_n=1, we_n=0. During it, address bit AP_BIT (default 8) is 1, all other address bits are 0 and the bank select is 0. T_RP_CYC NOP cycles follow it.
- R4: Exactly REFRESH_COUNT (at least 2) auto refresh commands are issued, each encoded cs_n=0, ras_n=0, cas_n=0, we_n=1 with address 0. Each one is followed by T_RFC_CYC NOP cycles.
- R5: The mode register write is encoded cs_n=0, ras_n=0, cas_n=0, we_n=0, with bank select 0. On the address pins, bits [2:0] carry the burst length code (1→0, 2→1, 4→2, 8→3, full page given as 0→7). Bit [3] carries BURST_INTERLEAVE, bits [6:4] carry CAS_LAT, and all higher bits are 0.
- R6: With MODE_FIRST=0 the order is precharge, then the refreshes, then the mode write. `init_done` rises in the cycle right after the mode write cycle.
- R7: With MODE_FIRST=1 the order is precharge, the mode write, T_MRD_CYC NOP cycles, then the refreshes. `init_done` rises in the cycle after the last refresh's T_RFC_CYC window.
- R8: Once `init_done` is high it stays high and the command is NOP until the next reset.
- R9: Asserting `rst_n` low partway through the sequence restarts it, so the full WAIT_CYC NOP window is repeated before the next precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; releasing it starts the sequence |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Multiplexed address / mode image |
| sd_dqm | output | DQM_W | Data byte masks |
| init_done | output | 1 | High once the memory is ready for use |

## Verification
The bench builds two instances side by side. The first uses the defaults: a 125 MHz clock, a 200 µs wait of 25000 cycles, two refreshes, burst length 4 in sequential order, CAS latency 3, and refreshes before the mode write. The second uses a 133.333 MHz clock with a 1 µs wait, so the cycle count must round up to 134. It also uses four refreshes, full-page interleaved bursts, CAS latency 2 and the mode write first, which brings the swapped order and the mode-set recovery gap into reach. The second instance is also reset partway through its wait so the restart is exercised.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        S_WAIT, S_PRE, S_TRP, S_REF, S_TRFC, S_MRS, S_TMRD, S_DONE
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Burst length in words to the 3-bit mode field; 0 stands for full page.
    function automatic logic [2:0] burst_code(int unsigned len);
        case (len)
            1:       return 3'd0;
            2:       return 3'd1;
            4:       return 3'd2;
            8:       return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    // Whole clock cycles covering a time span, rounded up.
    function automatic int unsigned ceil_cycles(longint unsigned span_ns,
                                                longint unsigned clk_khz);
        return int'((span_ns * clk_khz + 64'd999999) / 64'd1000000);
    endfunction

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (cnt_q != '1)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/sdram_init_encode.sv
module sdram_init_encode
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W           = 9,
    parameter int unsigned BA_W             = 1,
    parameter int unsigned AP_BIT           = 8,
    parameter int unsigned BURST_LEN        = 4,
    parameter int unsigned BURST_INTERLEAVE = 0,
    parameter int unsigned CAS_LAT          = 3
) (
    input  init_state_e       state,
    output sd_cmd_t           cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);
    localparam logic [2:0] BL_CODE = burst_code(BURST_LEN);
    localparam logic [2:0] CL_CODE = 3'(CAS_LAT);

    logic [ADDR_W-1:0] mode_img;
    logic [ADDR_W-1:0] pre_img;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_img
        if (i < 3) begin : g_bl
            assign mode_img[i] = BL_CODE[i];
        end else if (i == 3) begin : g_bt
            assign mode_img[i] = 1'(BURST_INTERLEAVE);
        end else if (i < 7) begin : g_cl
            assign mode_img[i] = CL_CODE[i-4];
        end else begin : g_zero
            assign mode_img[i] = 1'b0;
        end
        assign pre_img[i] = (i == AP_BIT);
    end

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        done = 1'b0;
        case (state)
            S_PRE: begin
                cmd  = CMD_PRE;
                addr = pre_img;
            end
            S_REF:  cmd = CMD_REF;
            S_MRS: begin
                cmd  = CMD_MRS;
                addr = mode_img;
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_KHZ          = 125000,
    parameter int unsigned WAIT_NS          = 200000,
    parameter int unsigned REFRESH_COUNT    = 2,
    parameter int unsigned T_RP_CYC         = 3,
    parameter int unsigned T_RFC_CYC        = 9,
    parameter int unsigned T_MRD_CYC        = 2,
    parameter int unsigned MODE_FIRST       = 0,
    parameter int unsigned BURST_LEN        = 4,
    parameter int unsigned BURST_INTERLEAVE = 0,
    parameter int unsigned CAS_LAT          = 3,
    parameter int unsigned ADDR_W           = 9,
    parameter int unsigned BA_W             = 1,
    parameter int unsigned AP_BIT           = 8,
    parameter int unsigned DQM_W            = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);
    localparam int unsigned WAIT_CYC = ceil_cycles(longint'(WAIT_NS), longint'(CLK_KHZ));
    localparam int unsigned MAX_CYC  = max4(WAIT_CYC, T_RP_CYC, T_RFC_CYC, T_MRD_CYC);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
    localparam int unsigned REF_W    = $clog2(REFRESH_COUNT + 1);

    typedef struct packed {
        init_state_e      st;
        logic [REF_W-1:0] refs;
    } fsm_t;

    fsm_t             fsm_d, fsm_q;
    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_cnt;
    sd_cmd_t          cmd;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            S_WAIT:
                if (tmr_cnt == CNT_W'(WAIT_CYC - 1)) fsm_d.st = S_PRE;
            S_PRE:
                fsm_d.st = S_TRP;
            S_TRP:
                if (tmr_cnt == CNT_W'(T_RP_CYC - 1))
                    fsm_d.st = (MODE_FIRST != 0) ? S_MRS : S_REF;
            S_REF: begin
                fsm_d.st   = S_TRFC;
                fsm_d.refs = fsm_q.refs + 1'b1;
            end
            S_TRFC:
                if (tmr_cnt == CNT_W'(T_RFC_CYC - 1)) begin
                    if (fsm_q.refs != REF_W'(REFRESH_COUNT))
                        fsm_d.st = S_REF;
                    else
                        fsm_d.st = (MODE_FIRST != 0) ? S_DONE : S_MRS;
                end
            S_MRS:
                fsm_d.st = (MODE_FIRST != 0) ? S_TMRD : S_DONE;
            S_TMRD:
                if (tmr_cnt == CNT_W'(T_MRD_CYC - 1)) fsm_d.st = S_REF;
            default:
                fsm_d.st = S_DONE;
        endcase
        tmr_clr = (fsm_d.st != fsm_q.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '{st: S_WAIT, refs: '0};
        else        fsm_q <= fsm_d;
    end

    sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr_cnt)
    );

    sdram_init_encode #(
        .ADDR_W           (ADDR_W),
        .BA_W             (BA_W),
        .AP_BIT           (AP_BIT),
        .BURST_LEN        (BURST_LEN),
        .BURST_INTERLEAVE (BURST_INTERLEAVE),
        .CAS_LAT          (CAS_LAT)
    ) u_encode (
        .state (fsm_q.st),
        .cmd   (cmd),
        .addr  (sd_addr),
        .ba    (sd_ba),
        .done  (init_done)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;
    assign sd_cke   = 1'b1;
    assign sd_dqm   = '1;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int unsigned WAIT_CYC         = 1,
    parameter int unsigned REFRESH_COUNT    = 2,
    parameter int unsigned MODE_FIRST       = 0,
    parameter int unsigned BURST_INTERLEAVE = 0,
    parameter int unsigned CAS_LAT          = 3,
    parameter int unsigned ADDR_W           = 9,
    parameter int unsigned BA_W             = 1,
    parameter int unsigned AP_BIT           = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);
    logic [3:0] c;
    assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    int unsigned since_rst;
    int unsigned nref;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 0;
            nref      <= 0;
        end else begin
            if (since_rst < WAIT_CYC) since_rst <= since_rst + 1;
            if (c == 4'b0001) nref <= nref + 1;
        end
    end

    // R2: nothing but NOP during the power-up wait
    a_r2_wait_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < WAIT_CYC) |-> (c == 4'b0111));

    // R3: precharge closes all banks through the AP bit alone
    a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010) |-> (sd_addr[AP_BIT] && $countones(sd_addr) == 1 && sd_ba == '0));

    // R3: precharge is followed by a NOP
    a_r3_gap_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010) |=> (c == 4'b0111));

    // R4: the requested number of refreshes has happened before done
    a_r4_refresh_count: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (nref == REFRESH_COUNT));

    // R5: mode image fields
    a_r5_mode_image: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0000) |-> (sd_addr[3] == 1'(BURST_INTERLEAVE) &&
                            sd_addr[6:4] == 3'(CAS_LAT) &&
                            (sd_addr >> 7) == '0 && sd_ba == '0));

    // R6: done rises straight after the mode write in the default order
    a_r6_done_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE_FIRST == 0 && $rose(init_done)) |-> ($past(c) == 4'b0000));

    // R8: done is sticky and the bus is idle afterwards
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r8_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (c == 4'b0111));
endmodule

bind sdram_init_seq sdram_init_chk #(
    .WAIT_CYC         (WAIT_CYC),
    .REFRESH_COUNT    (REFRESH_COUNT),
    .MODE_FIRST       (MODE_FIRST),
    .BURST_INTERLEAVE (BURST_INTERLEAVE),
    .CAS_LAT          (CAS_LAT),
    .ADDR_W           (ADDR_W),
    .BA_W             (BA_W),
    .AP_BIT           (AP_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .init_done (init_done)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
    typedef logic [14:0] word_t;   // {done, cs_n, ras_n, cas_n, we_n, ba, addr[8:0]}
    typedef word_t wq_t[$];

    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

    // instance A: defaults
    localparam int A_KHZ = 125000, A_NS = 200000, A_NREF = 2, A_TRP = 3, A_TRFC = 9,
                   A_TMRD = 2, A_MF = 0, A_BL = 4, A_IL = 0, A_CL = 3;
    // instance B: rounding, swapped order, full page
    localparam int B_KHZ = 133333, B_NS = 1000, B_NREF = 4, B_TRP = 2, B_TRFC = 5,
                   B_TMRD = 3, B_MF = 1, B_BL = 0, B_IL = 1, B_CL = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_a_n = 1'b0, rst_b_n = 1'b0;

    logic       a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [0:0] a_ba;
    logic [8:0] a_addr;
    logic [1:0] a_dqm;
    logic       b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [0:0] b_ba;
    logic [8:0] b_addr;
    logic [1:0] b_dqm;

    sdram_init_seq i_sdram_init_seq (
        .clk(clk), .rst_n(rst_a_n), .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
        .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_ba(a_ba), .sd_addr(a_addr),
        .sd_dqm(a_dqm), .init_done(a_done)
    );

    sdram_init_seq #(
        .CLK_KHZ(B_KHZ), .WAIT_NS(B_NS), .REFRESH_COUNT(B_NREF), .T_RP_CYC(B_TRP),
        .T_RFC_CYC(B_TRFC), .T_MRD_CYC(B_TMRD), .MODE_FIRST(B_MF), .BURST_LEN(B_BL),
        .BURST_INTERLEAVE(B_IL), .CAS_LAT(B_CL)
    ) i_sdram_init_seq_b (
        .clk(clk), .rst_n(rst_b_n), .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
        .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_ba(b_ba), .sd_addr(b_addr),
        .sd_dqm(b_dqm), .init_done(b_done)
    );

    int vectors = 0, errors = 0;

    task automatic check(string tag, string inst, longint got, longint exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s inst %s: got %0h expected %0h at %0t", tag, inst, got, exp, $time);
        end
    endtask

    function automatic int wait_cycles(longint ns, longint khz);
        return int'((ns * khz + 999999) / 1000000);
    endfunction

    function automatic logic [2:0] bl_field(int bl);
        int r = 0;
        if (bl == 0) return 3'd7;
        while ((1 << r) < bl) r++;
        return 3'(r);
    endfunction

    function automatic word_t w(logic done, logic [3:0] c, logic [8:0] a);
        return {done, c, 1'b0, a};
    endfunction

    function automatic wq_t build(int wc, int trp, int trfc, int tmrd, int nref,
                                  int mf, int bl, int il, int cl);
        wq_t q;
        word_t mrs_w;
        mrs_w = w(1'b0, MRS, {2'b00, 3'(cl), 1'(il), bl_field(bl)});
        repeat (wc) q.push_back(w(1'b0, NOP, 9'd0));
        q.push_back(w(1'b0, PRE, 9'h100));
        repeat (trp) q.push_back(w(1'b0, NOP, 9'd0));
        if (mf != 0) begin
            q.push_back(mrs_w);
            repeat (tmrd) q.push_back(w(1'b0, NOP, 9'd0));
        end
        for (int i = 0; i < nref; i++) begin
            q.push_back(w(1'b0, REF, 9'd0));
            repeat (trfc) q.push_back(w(1'b0, NOP, 9'd0));
        end
        if (mf == 0) q.push_back(mrs_w);
        return q;
    endfunction

    function automatic string tag_of(word_t e);
        if (e[14]) return "R8";
        case (e[13:10])
            PRE:     return "R3";
            REF:     return "R4";
            MRS:     return "R5";
            default: return "R2";
        endcase
    endfunction

    localparam int WA = 0;
    int  wait_a, wait_b;
    wq_t qa, qb;
    int  len_a, len_b, cyc_a, cyc_b, refs_a, refs_b;
    bit  live_a, live_b, seen_a, seen_b, b_restarted, b_pre_seen;

    initial begin
        wait_a = wait_cycles(A_NS, A_KHZ);
        wait_b = wait_cycles(B_NS, B_KHZ);
    end

    // reference model: advances on every rising edge
    always @(posedge clk) begin
        if (!rst_a_n) begin
            qa = build(wait_a, A_TRP, A_TRFC, A_TMRD, A_NREF, A_MF, A_BL, A_IL, A_CL);
            len_a = qa.size(); cyc_a = 0; refs_a = 0; seen_a = 0; live_a = 1;
        end else begin
            if (qa.size() > 0) void'(qa.pop_front());
            cyc_a++;
        end
        if (!rst_b_n) begin
            qb = build(wait_b, B_TRP, B_TRFC, B_TMRD, B_NREF, B_MF, B_BL, B_IL, B_CL);
            len_b = qb.size(); cyc_b = 0; refs_b = 0; seen_b = 0; b_pre_seen = 0; live_b = 1;
        end else begin
            if (qb.size() > 0) void'(qb.pop_front());
            cyc_b++;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        word_t ea, eb, ga, gb;
        if (live_a) begin
            ea = (qa.size() > 0) ? qa[0] : w(1'b1, NOP, 9'd0);
            ga = {a_done, a_cs, a_ras, a_cas, a_we, a_ba, a_addr};
            check(tag_of(ea), "A", ga, ea);
            check("R1", "A", {a_cke, a_dqm}, 3'b111);
            if (ga[13:10] == REF && rst_a_n) refs_a++;
            if (a_done && !seen_a) begin
                seen_a = 1;
                check("R6", "A", cyc_a, len_a);
                check("R4", "A", refs_a, A_NREF);
            end
        end
        if (live_b) begin
            eb = (qb.size() > 0) ? qb[0] : w(1'b1, NOP, 9'd0);
            gb = {b_done, b_cs, b_ras, b_cas, b_we, b_ba, b_addr};
            check(tag_of(eb), "B", gb, eb);
            check("R1", "B", {b_cke, b_dqm}, 3'b111);
            if (gb[13:10] == REF && rst_b_n) refs_b++;
            if (gb[13:10] == PRE && b_restarted && !b_pre_seen) begin
                b_pre_seen = 1;
                check("R9", "B", cyc_b, wait_b);
            end
            if (b_done && !seen_b) begin
                seen_b = 1;
                check("R7", "B", cyc_b, len_b);
                check("R4", "B", refs_b, B_NREF);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "A", {a_done, a_cs, a_ras, a_cas, a_we}, {1'b0, NOP});
        check("R1", "B", {b_done, b_cs, b_ras, b_cas, b_we}, {1'b0, NOP});
        rst_a_n = 1'b1;
        rst_b_n = 1'b1;
        repeat (60) @(negedge clk);
        rst_b_n     = 1'b0;        // R9: restart B in the middle of its wait
        b_restarted = 1'b1;
        repeat (2) @(negedge clk);
        rst_b_n = 1'b1;
        for (int i = 0; i < 40000 && !(seen_a && seen_b); i++) @(negedge clk);
        if (!(seen_a && seen_b)) begin
            errors++;
            $display("FAIL R6 watchdog: done A=%0d B=%0d expected both 1", seen_a, seen_b);
        end
        repeat (20) @(negedge clk);
        check("R9", "B", b_pre_seen, 1);
        check("R8", "A", {a_done, a_cs, a_ras, a_cas, a_we}, {1'b1, NOP});
        check("R8", "B", {b_done, b_cs, b_ras, b_cas, b_we}, {1'b1, NOP});
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule